// File: doc/BRIEF.md
# Microprogram Sequencer with Opcode Dispatch

This block steps a multicycle processor through the control states of each instruction. A 4-bit micro-program counter selects one word in a constant microcode store. Each word drives the datapath's control points directly: instruction-register load, PC load, branch-target select, operand latch enables, ALU operation, result latch enable, data memory read and write, register-file write, destination choice and write-back source. A 2-bit sequencing field in the same word tells the counter what to do next. The field is encoded 00 hold, 01 step to the next address, 10 dispatch on the opcode, 11 return to the fetch state at address 0.

Dispatch goes through a small opcode map. The map covers five instructions: register-register ALU, OR with immediate, load word, store word and branch-if-equal. Any opcode not in the map goes back to address 0. A stall input freezes the counter whenever it is asserted, whatever the current word requests, so that a slow memory can be waited on. The branch-select output follows the condition input during the branch state. All other outputs come straight from a register.

Top module: `microseq_ctrl`

## Requirements
- R1: A synchronous active-high reset sets upc_o to 0 and presents the fetch word: ir_en is 1 and every other control output is 0.
- R2: At address 0 (fetch) with no stall, the next address is 1. At address 1 (decode) a_en and b_en are 1.
- R3: Leaving address 1 dispatches on opcode: 000000 goes to 4, 000100 to 3, 001101 to 6, 100011 to 8 and 101011 to 11.
- R4: An opcode that is not in the map sends the sequencer from address 1 back to address 0.
- R5: The register-register path runs 4, 5, 0. Address 4 gives alu_op 2'b10 and s_en. Address 5 gives rf_wr, rf_dst_rd and pc_en.
- R6: The OR-immediate path runs 6, 7, 0. Address 6 gives alu_op 2'b01 and s_en. Address 7 gives rf_wr and pc_en, with rf_dst_rd at 0.
- R7: The load path runs 8, 9, 10, 0. Address 8 gives alu_op 2'b00 and s_en, address 9 gives mem_rd, and address 10 gives rf_wr, rf_from_mem and pc_en.
- R8: The store path runs 11, 12, 0. Address 11 gives alu_op 2'b00 and s_en. Address 12 gives mem_wr and pc_en.
- R9: At address 3 (branch), pc_en is 1 and pc_br_sel equals the taken input in the same cycle. The next address is 0 for either value of taken.
- R10: While stall is 1, upc_o and every registered control output keep their values. When stall returns to 0, the sequence resumes from the held address.
- R11: The opcode is used only when leaving address 1. Changing it in any other state has no effect on the path being run.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| opcode | input | 6 | Instruction opcode used for dispatch |
| taken | input | 1 | Branch condition (operands equal) |
| stall | input | 1 | Hold the sequencer in its current state |
| upc_o | output | 4 | Current micro-program counter |
| ir_en | output | 1 | Load instruction register |
| pc_en | output | 1 | Load program counter |
| pc_br_sel | output | 1 | PC source: 1 = branch target, 0 = PC + 4 |
| a_en | output | 1 | Latch operand A |
| b_en | output | 1 | Latch operand B |
| alu_op | output | 2 | 00 add, 01 OR, 10 function field |
| s_en | output | 1 | Latch ALU result |
| mem_rd | output | 1 | Data memory read |
| mem_wr | output | 1 | Data memory write |
| rf_wr | output | 1 | Register file write |
| rf_dst_rd | output | 1 | Destination is rd (1) or rt (0) |
| rf_from_mem | output | 1 | Write-back from memory data (1) or ALU result (0) |

## Verification
Each of the five mapped opcodes is driven through decode, and both the address sequence and the full control word are compared in every state. This tells apart dispatch targets that differ by one entry, and words that differ in a single field. Two unmapped opcodes show whether the default goes to fetch or falls through to a neighbour. The branch opcode is run with taken at 0 and then at 1 inside the same state, which separates a live select from a latched one. Stalls in the fetch state and in the middle of the load path, together with an opcode change during execution, show whether hold and dispatch are applied only where they belong.

// File: rtl/useq_pkg.sv
package useq_pkg;

  typedef enum logic [1:0] {
    SEQ_HOLD     = 2'b00,
    SEQ_INC      = 2'b01,
    SEQ_DISPATCH = 2'b10,
    SEQ_RESTART  = 2'b11
  } seq_op_e;

  typedef enum logic [1:0] {
    ALU_ADD   = 2'b00,
    ALU_OR    = 2'b01,
    ALU_FUNCT = 2'b10
  } alu_sel_e;

  typedef struct packed {
    logic     ir_load;
    logic     pc_load;
    logic     br_cond;
    logic     a_load;
    logic     b_load;
    alu_sel_e alu;
    logic     s_load;
    logic     dmem_rd;
    logic     dmem_wr;
    logic     rf_we;
    logic     rf_dst_rd;
    logic     rf_wb_mem;
    seq_op_e  seq;
  } uword_t;

  // opcode values and their entry addresses
  localparam int OPC_ALU   = 6'b000000;
  localparam int OPC_BEQ   = 6'b000100;
  localparam int OPC_ORI   = 6'b001101;
  localparam int OPC_LOAD  = 6'b100011;
  localparam int OPC_STORE = 6'b101011;

  localparam int UA_FETCH  = 0;
  localparam int UA_DECODE = 1;
  localparam int UA_BRANCH = 3;
  localparam int UA_ALU_EX = 4;
  localparam int UA_ALU_WB = 5;
  localparam int UA_ORI_EX = 6;
  localparam int UA_ORI_WB = 7;
  localparam int UA_LD_EX  = 8;
  localparam int UA_LD_MEM = 9;
  localparam int UA_LD_WB  = 10;
  localparam int UA_ST_EX  = 11;
  localparam int UA_ST_MEM = 12;

  // Microprogram contents, one word per address.
  function automatic uword_t uword_at(input int addr);
    uword_t w;
    w = '0;
    w.alu = ALU_ADD;
    w.seq = SEQ_RESTART;
    case (addr)
      UA_FETCH:  begin w.ir_load = 1'b1; w.seq = SEQ_INC; end
      UA_DECODE: begin w.a_load = 1'b1; w.b_load = 1'b1; w.seq = SEQ_DISPATCH; end
      UA_BRANCH: begin w.pc_load = 1'b1; w.br_cond = 1'b1; end
      UA_ALU_EX: begin w.alu = ALU_FUNCT; w.s_load = 1'b1; w.seq = SEQ_INC; end
      UA_ALU_WB: begin w.rf_we = 1'b1; w.rf_dst_rd = 1'b1; w.pc_load = 1'b1; end
      UA_ORI_EX: begin w.alu = ALU_OR; w.s_load = 1'b1; w.seq = SEQ_INC; end
      UA_ORI_WB: begin w.rf_we = 1'b1; w.pc_load = 1'b1; end
      UA_LD_EX:  begin w.s_load = 1'b1; w.seq = SEQ_INC; end
      UA_LD_MEM: begin w.dmem_rd = 1'b1; w.seq = SEQ_INC; end
      UA_LD_WB:  begin w.rf_we = 1'b1; w.rf_wb_mem = 1'b1; w.pc_load = 1'b1; end
      UA_ST_EX:  begin w.s_load = 1'b1; w.seq = SEQ_INC; end
      UA_ST_MEM: begin w.dmem_wr = 1'b1; w.pc_load = 1'b1; end
      default:   w.seq = SEQ_RESTART;
    endcase
    return w;
  endfunction

endpackage

// File: rtl/useq_map_rom.sv
module useq_map_rom #(
  parameter int OP_W  = 6,
  parameter int UPC_W = 4
) (
  input  logic [OP_W-1:0]  opcode,
  output logic [UPC_W-1:0] target
);
  import useq_pkg::*;

  always_comb begin
    if      (opcode == OP_W'(OPC_ALU))   target = UPC_W'(UA_ALU_EX);
    else if (opcode == OP_W'(OPC_BEQ))   target = UPC_W'(UA_BRANCH);
    else if (opcode == OP_W'(OPC_ORI))   target = UPC_W'(UA_ORI_EX);
    else if (opcode == OP_W'(OPC_LOAD))  target = UPC_W'(UA_LD_EX);
    else if (opcode == OP_W'(OPC_STORE)) target = UPC_W'(UA_ST_EX);
    else                                 target = UPC_W'(UA_FETCH);
  end

endmodule

// File: rtl/useq_next.sv
module useq_next #(
  parameter int UPC_W = 4
) (
  input  logic                 rst,
  input  logic                 stall,
  input  logic [UPC_W-1:0]     upc,
  input  useq_pkg::seq_op_e    seq,
  input  logic [UPC_W-1:0]     dispatch_tgt,
  output logic [UPC_W-1:0]     upc_nxt
);
  import useq_pkg::*;

  always_comb begin
    if (rst) begin
      upc_nxt = '0;
    end else if (stall) begin
      upc_nxt = upc;
    end else begin
      case (seq)
        SEQ_INC:      upc_nxt = upc + UPC_W'(1);
        SEQ_DISPATCH: upc_nxt = dispatch_tgt;
        SEQ_RESTART:  upc_nxt = '0;
        default:      upc_nxt = upc;
      endcase
    end
  end

endmodule

// File: rtl/useq_store.sv
module useq_store #(
  parameter int UPC_W = 4
) (
  input  logic                  clk,
  input  logic [UPC_W-1:0]      rd_addr,
  output useq_pkg::uword_t      rd_word
);
  import useq_pkg::*;

  localparam int DEPTH = 1 << UPC_W;

  uword_t rom [DEPTH];

  for (genvar i = 0; i < DEPTH; i++) begin : g_word
    assign rom[i] = uword_at(i);
  end

  // synchronous read keeps the store mappable onto block RAM
  always_ff @(posedge clk) begin
    rd_word <= rom[rd_addr];
  end

endmodule

// File: rtl/microseq_ctrl.sv
module microseq_ctrl #(
  parameter int OP_W  = 6,
  parameter int UPC_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [OP_W-1:0]  opcode,
  input  logic             taken,
  input  logic             stall,
  output logic [UPC_W-1:0] upc_o,
  output logic             ir_en,
  output logic             pc_en,
  output logic             pc_br_sel,
  output logic             a_en,
  output logic             b_en,
  output logic [1:0]       alu_op,
  output logic             s_en,
  output logic             mem_rd,
  output logic             mem_wr,
  output logic             rf_wr,
  output logic             rf_dst_rd,
  output logic             rf_from_mem
);
  import useq_pkg::*;

  logic [UPC_W-1:0] upc_q;
  logic [UPC_W-1:0] upc_nxt;
  logic [UPC_W-1:0] map_tgt;
  uword_t           word_q;

  useq_map_rom #(.OP_W(OP_W), .UPC_W(UPC_W)) u_map (
    .opcode (opcode),
    .target (map_tgt)
  );

  useq_next #(.UPC_W(UPC_W)) u_next (
    .rst          (rst),
    .stall        (stall),
    .upc          (upc_q),
    .seq          (word_q.seq),
    .dispatch_tgt (map_tgt),
    .upc_nxt      (upc_nxt)
  );

  // word_q is read at the address being loaded, so it always matches upc_q
  useq_store #(.UPC_W(UPC_W)) u_store (
    .clk     (clk),
    .rd_addr (upc_nxt),
    .rd_word (word_q)
  );

  always_ff @(posedge clk) begin
    upc_q <= upc_nxt;
  end

  assign upc_o       = upc_q;
  assign ir_en       = word_q.ir_load;
  assign pc_en       = word_q.pc_load;
  assign pc_br_sel   = word_q.br_cond & taken;
  assign a_en        = word_q.a_load;
  assign b_en        = word_q.b_load;
  assign alu_op      = word_q.alu;
  assign s_en        = word_q.s_load;
  assign mem_rd      = word_q.dmem_rd;
  assign mem_wr      = word_q.dmem_wr;
  assign rf_wr       = word_q.rf_we;
  assign rf_dst_rd   = word_q.rf_dst_rd;
  assign rf_from_mem = word_q.rf_wb_mem;

endmodule

// File: rtl/microseq_ctrl_chk.sv
module microseq_ctrl_chk #(
  parameter int OP_W  = 6,
  parameter int UPC_W = 4
) (
  input logic             clk,
  input logic             rst,
  input logic [OP_W-1:0]  opcode,
  input logic             stall,
  input logic [UPC_W-1:0] upc_o,
  input logic             pc_en,
  input logic             pc_br_sel,
  input logic             mem_rd,
  input logic             mem_wr
);

  // R1
  reset_to_fetch_chk: assert property (@(posedge clk)
    rst |=> (upc_o == '0));

  // R10
  stall_hold_chk: assert property (@(posedge clk) disable iff (rst)
    stall |=> (upc_o == $past(upc_o)));

  // R3
  dispatch_target_chk: assert property (@(posedge clk) disable iff (rst)
    (upc_o == UPC_W'(1) && !stall && opcode == OP_W'(6'b100011)) |=> (upc_o == UPC_W'(8)));

  // R4
  dispatch_legal_chk: assert property (@(posedge clk) disable iff (rst)
    (upc_o == UPC_W'(1) && !stall) |=>
      (upc_o == UPC_W'(0) || upc_o == UPC_W'(3) || upc_o == UPC_W'(4) ||
       upc_o == UPC_W'(6) || upc_o == UPC_W'(8) || upc_o == UPC_W'(11)));

  // R9
  pc_update_returns_chk: assert property (@(posedge clk) disable iff (rst)
    (pc_en && !stall) |=> (upc_o == '0));

  // R9
  br_sel_needs_pc_en_chk: assert property (@(posedge clk) disable iff (rst)
    pc_br_sel |-> pc_en);

  // R8
  mem_dir_excl_chk: assert property (@(posedge clk) disable iff (rst)
    !(mem_rd && mem_wr));

endmodule

bind microseq_ctrl microseq_ctrl_chk #(.OP_W(OP_W), .UPC_W(UPC_W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .opcode    (opcode),
  .stall     (stall),
  .upc_o     (upc_o),
  .pc_en     (pc_en),
  .pc_br_sel (pc_br_sel),
  .mem_rd    (mem_rd),
  .mem_wr    (mem_wr)
);

// File: tb/sim_microseq_ctrl.sv
`timescale 1ns/1ps
module sim_microseq_ctrl;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [5:0] opcode = 6'd0;
  logic       taken = 1'b0;
  logic       stall = 1'b0;
  logic [3:0] upc_o;
  logic       ir_en, pc_en, pc_br_sel, a_en, b_en, s_en;
  logic       mem_rd, mem_wr, rf_wr, rf_dst_rd, rf_from_mem;
  logic [1:0] alu_op;

  int n_chk = 0;
  int n_fail = 0;

  always #4 clk = ~clk;

  microseq_ctrl u0 (
    .clk(clk), .rst(rst), .opcode(opcode), .taken(taken), .stall(stall),
    .upc_o(upc_o), .ir_en(ir_en), .pc_en(pc_en), .pc_br_sel(pc_br_sel),
    .a_en(a_en), .b_en(b_en), .alu_op(alu_op), .s_en(s_en),
    .mem_rd(mem_rd), .mem_wr(mem_wr), .rf_wr(rf_wr),
    .rf_dst_rd(rf_dst_rd), .rf_from_mem(rf_from_mem)
  );

  wire [12:0] cw = {ir_en, pc_en, pc_br_sel, a_en, b_en, alu_op, s_en,
                    mem_rd, mem_wr, rf_wr, rf_dst_rd, rf_from_mem};

  // expected control word per address, taken from the requirements
  function automatic logic [12:0] exp_cw(input int u, input logic tk);
    logic ir, pc, br, a, b, s, mr, mw, rw, dst, wbm;
    logic [1:0] alu;
    {ir, pc, br, a, b, s, mr, mw, rw, dst, wbm} = '0;
    alu = 2'b00;
    case (u)
      0:  ir = 1'b1;
      1:  begin a = 1'b1; b = 1'b1; end
      3:  begin pc = 1'b1; br = tk; end
      4:  begin alu = 2'b10; s = 1'b1; end
      5:  begin rw = 1'b1; dst = 1'b1; pc = 1'b1; end
      6:  begin alu = 2'b01; s = 1'b1; end
      7:  begin rw = 1'b1; pc = 1'b1; end
      8:  s = 1'b1;
      9:  mr = 1'b1;
      10: begin rw = 1'b1; wbm = 1'b1; pc = 1'b1; end
      11: s = 1'b1;
      12: begin mw = 1'b1; pc = 1'b1; end
      default: ;
    endcase
    return {ir, pc, br, a, b, alu, s, mr, mw, rw, dst, wbm};
  endfunction

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic check(input string req, input string what, input int act, input int exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic expect_at(input string req, input int u);
    check(req, "upc", int'(upc_o), u);
    check(req, "ctrl", int'(cw), int'(exp_cw(u, taken)));
  endtask

  task automatic t_reset();
    rst = 1'b1;
    tick(); tick();
    rst = 1'b0;
    expect_at("R1", 0);
  endtask

  task automatic t_alu();
    opcode = 6'b000000;
    expect_at("R2", 0);
    tick(); expect_at("R2", 1);
    tick(); expect_at("R3", 4);
    opcode = 6'b100011;            // R11: change after dispatch
    tick(); expect_at("R11", 5);
    tick(); expect_at("R5", 0);
  endtask

  task automatic t_ori();
    opcode = 6'b001101;
    tick(); expect_at("R2", 1);
    tick(); expect_at("R6", 6);
    tick(); expect_at("R6", 7);
    tick(); expect_at("R6", 0);
  endtask

  task automatic t_load();
    opcode = 6'b100011;
    tick(); expect_at("R2", 1);
    tick(); expect_at("R7", 8);
    tick(); expect_at("R7", 9);
    tick(); expect_at("R7", 10);
    tick(); expect_at("R7", 0);
  endtask

  task automatic t_store();
    opcode = 6'b101011;
    tick(); expect_at("R2", 1);
    tick(); expect_at("R8", 11);
    opcode = 6'b000100;            // R11: ignored outside decode
    tick(); expect_at("R8", 12);
    tick(); expect_at("R8", 0);
  endtask

  task automatic t_branch(input logic tk_last);
    opcode = 6'b000100;
    taken = 1'b0;
    tick(); expect_at("R3", 1);
    tick(); expect_at("R9", 3);
    check("R9", "br_sel low", int'(pc_br_sel), 0);
    taken = 1'b1;
    #1;
    check("R9", "br_sel high", int'(pc_br_sel), 1);
    expect_at("R9", 3);
    taken = tk_last;
    tick(); expect_at("R9", 0);
    taken = 1'b0;
  endtask

  task automatic t_unmapped(input logic [5:0] op);
    opcode = op;
    tick(); expect_at("R4", 1);
    tick(); expect_at("R4", 0);
  endtask

  task automatic t_stall();
    opcode = 6'b100011;
    stall = 1'b1;
    for (int i = 0; i < 3; i++) begin
      tick(); expect_at("R10", 0);
    end
    stall = 1'b0;
    tick(); expect_at("R10", 1);
    tick(); expect_at("R7", 8);
    tick(); expect_at("R7", 9);
    stall = 1'b1;
    for (int i = 0; i < 2; i++) begin
      tick(); expect_at("R10", 9);
    end
    stall = 1'b0;
    tick(); expect_at("R10", 10);
    tick(); expect_at("R10", 0);
  endtask

  initial begin
    t_reset();
    t_alu();
    t_ori();
    t_load();
    t_store();
    t_branch(1'b0);
    t_branch(1'b1);
    t_unmapped(6'b111111);
    t_unmapped(6'b000001);
    t_stall();
    t_reset();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual running expected finished");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

endmodule